// File: doc/BRIEF.md
# Periodic Beep Tone Generator

This block produces a square-wave alert tone that is summed into a 24-bit audio sample stream. All of its timing is counted in sample periods: a one-cycle `sample_en` strobe marks each new sample, and nothing advances between strobes. Because of this, the pitch and the burst lengths scale with the sample rate. A 4-bit frequency code selects the tone's half-period. A 4-bit on-time code sets the burst length and a 3-bit off-time code sets the gap between bursts.

A 2-bit mode field and a repeat bit choose how the tone runs. The tone can play one burst and stop, play bursts separated by silent gaps, or sound without interruption. The tone swings between +A and -A, where A is an 8-bit amplitude placed in the upper bits of the 24-bit sample. The output is zero whenever no burst is sounding. The tone is added to the incoming audio with saturation.

The sequencer has four states:
- IDLE: beep off.
- TONE: burst sounding.
- GAP: silent interval between repeated bursts.
- DONE: a single burst has finished and the block waits for the mode to be cleared.

The transitions are:
- IDLE→TONE (start) on the first strobe that sees a non-zero mode after a strobe that saw zero.
- TONE→DONE (single end) when a burst finishes in single mode.
- TONE→GAP (burst end) when a burst finishes in periodic mode.
- GAP→TONE (gap end) when the gap count expires.
- TONE/GAP/DONE→IDLE (stop) on any strobe that sees mode zero.

In continuous mode, TONE stays in TONE.

Top module: `beep_gen`

## Requirements
- R1: After reset, `beep_active` is 0, `beep_out` is 0 and `mix_out` equals `audio_in`.
- R2: The mode encoding is as follows. 2'b00 is off. 2'b01 is single burst, and `repeat_en` is ignored. 2'b10 and 2'b11 both select multi mode: with `repeat_en`=1 the bursts are periodic, and with `repeat_en`=0 the tone is continuous. A start takes effect on the strobe that sees the mode change, and the tone is present from the next cycle.
- R3: The tone half-period is H = 92 - floor(81*code/15) samples, where code is `freq_code` (92 for code 0, 11 for code 15). Each burst begins with H samples at +A, then alternates sign every H samples.
- R4: A equals `amp` shifted left by 15 as an unsigned value, so the top bit of `beep_out` is never set by A.
- R5: A burst lasts ON_UNIT*(`on_code`+1) samples.
- R6: In single mode, exactly one burst is produced. After it, the outputs stay silent until the mode returns to 2'b00 and is set non-zero again.
- R7: In periodic mode, each burst is followed by a gap of OFF_MIN+OFF_STEP*`off_code` silent samples, and then a new burst that again starts at +A.
- R8: In continuous mode, the tone runs with no gaps for as long as the mode stays set.
- R9: A strobe that sees mode 2'b00 silences the block from the next cycle. A later re-enable restarts the burst count from zero, at +A.
- R10: `beep_active` is 1 exactly during bursts, and `beep_out` is 0 whenever it is 0.
- R11: `mix_out` is `audio_in` + `beep_out`, clamped to the range [-2^23, 2^23-1].
- R12: In cycles where `sample_en` is 0, no counter or state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe per sample period |
| mode | input | 2 | 00 off, 01 single, 1x multi |
| repeat_en | input | 1 | In multi mode: 1 periodic, 0 continuous |
| freq_code | input | 4 | Half-period selection |
| on_code | input | 4 | Burst length selection |
| off_code | input | 3 | Gap length selection |
| amp | input | 8 | Tone amplitude |
| audio_in | input | 24 | Signed audio sample |
| beep_out | output | 24 | Signed tone sample |
| beep_active | output | 1 | High during bursts |
| mix_out | output | 24 | Saturated sum of audio and tone |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- Burst edges: an off-by-one burst or gap counter shifts every later edge by a sample.
- Re-enabling after a stop or after a finished single burst: a design that kept its old count or tone phase would start mid-burst or at -A.
- Sparse strobes: a block that counted clocks instead of samples would run fast.
- Audio near both rails: a wrapping adder would flip the sign of `mix_out` instead of clamping.
- The duplicate multi encoding 2'b11: a decoder that treated 2'b11 differently would be caught.

// File: rtl/beep_pkg.sv
package beep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TONE,
        ST_GAP,
        ST_DONE
    } beep_state_t;

    localparam logic [1:0] MODE_OFF    = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;

    // Half-period in samples: linear from hmax (code 0) down to hmin (top code).
    function automatic int half_period(input int code, input int steps,
                                       input int hmax, input int hmin);
        return hmax - ((hmax - hmin) * code) / steps;
    endfunction

endpackage

// File: rtl/beep_fsm.sv
module beep_fsm
    import beep_pkg::*;
#(
    parameter int ONCODE_W  = 4,
    parameter int OFFCODE_W = 3,
    parameter int ON_UNIT   = 1024,
    parameter int OFF_MIN   = 3600,
    parameter int OFF_STEP  = 4149
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [1:0]           mode,
    input  logic                 repeat_en,
    input  logic [ONCODE_W-1:0]  on_code,
    input  logic [OFFCODE_W-1:0] off_code,
    output beep_state_t          state
);
    localparam int ON_MAX  = ON_UNIT * (1 << ONCODE_W);
    localparam int OFF_MAX = OFF_MIN + OFF_STEP * ((1 << OFFCODE_W) - 1);
    localparam int CNT_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    beep_state_t      state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] on_len, off_len;
    logic             en_q;
    logic             en, single, cont;

    assign en      = (mode != MODE_OFF);
    assign single  = (mode == MODE_SINGLE);
    assign cont    = mode[1] && !repeat_en;
    assign on_len  = CNT_W'(ON_UNIT) * (CNT_W'(on_code) + CNT_W'(1));
    assign off_len = CNT_W'(OFF_MIN) + CNT_W'(OFF_STEP) * CNT_W'(off_code);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (en && !en_q) state_n = ST_TONE;
            end
            ST_TONE: begin
                if (!en) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (cont) begin
                    cnt_n = '0;
                end else if (cnt == on_len - CNT_W'(1)) begin
                    cnt_n   = '0;
                    state_n = single ? ST_DONE : ST_GAP;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (!en) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (cnt == off_len - CNT_W'(1)) begin
                    cnt_n   = '0;
                    state_n = ST_TONE;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_DONE: begin
                cnt_n = '0;
                if (!en) state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            en_q  <= 1'b0;
        end else if (tick) begin
            state <= state_n;
            cnt   <= cnt_n;
            en_q  <= en;
        end
    end

endmodule

// File: rtl/beep_tone.sv
module beep_tone
    import beep_pkg::*;
#(
    parameter int FCODE_W  = 4,
    parameter int HALF_MAX = 92,
    parameter int HALF_MIN = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic [FCODE_W-1:0] freq_code,
    output logic               phase_neg
);
    localparam int FSTEPS  = (1 << FCODE_W) - 1;
    localparam int HALF_CW = $clog2(HALF_MAX + 1);

    logic [HALF_CW-1:0] half_len;
    logic [HALF_CW-1:0] tcnt;

    always_comb begin
        half_len = HALF_CW'(half_period(int'(freq_code), FSTEPS, HALF_MAX, HALF_MIN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            phase_neg <= 1'b0;
        end else if (tick) begin
            if (!run) begin
                tcnt      <= '0;
                phase_neg <= 1'b0;
            end else if (tcnt == half_len - HALF_CW'(1)) begin
                tcnt      <= '0;
                phase_neg <= !phase_neg;
            end else begin
                tcnt <= tcnt + HALF_CW'(1);
            end
        end
    end

endmodule

// File: rtl/beep_mix.sv
module beep_mix #(
    parameter int SAMPLE_W = 24,
    parameter int AMP_W    = 8
) (
    input  logic                       active,
    input  logic                       phase_neg,
    input  logic [AMP_W-1:0]           amp,
    input  logic signed [SAMPLE_W-1:0] audio_in,
    output logic signed [SAMPLE_W-1:0] beep_out,
    output logic signed [SAMPLE_W-1:0] mix_out
);
    localparam int PAD = SAMPLE_W - 1 - AMP_W;
    localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] mag;
    logic signed [SAMPLE_W:0]   sum;

    always_comb begin
        mag = {1'b0, amp, {PAD{1'b0}}};
        if (!active)        beep_out = '0;
        else if (phase_neg) beep_out = -mag;
        else                beep_out = mag;

        sum = {audio_in[SAMPLE_W-1], audio_in} + {beep_out[SAMPLE_W-1], beep_out};
        if (sum[SAMPLE_W] != sum[SAMPLE_W-1])
            mix_out = sum[SAMPLE_W] ? S_MIN : S_MAX;
        else
            mix_out = sum[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/beep_gen.sv
module beep_gen
    import beep_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int AMP_W     = 8,
    parameter int FCODE_W   = 4,
    parameter int ONCODE_W  = 4,
    parameter int OFFCODE_W = 3,
    parameter int HALF_MAX  = 92,
    parameter int HALF_MIN  = 11,
    parameter int ON_UNIT   = 1024,
    parameter int OFF_MIN   = 3600,
    parameter int OFF_STEP  = 4149
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_en,
    input  logic [1:0]                 mode,
    input  logic                       repeat_en,
    input  logic [FCODE_W-1:0]         freq_code,
    input  logic [ONCODE_W-1:0]        on_code,
    input  logic [OFFCODE_W-1:0]       off_code,
    input  logic [AMP_W-1:0]           amp,
    input  logic signed [SAMPLE_W-1:0] audio_in,
    output logic signed [SAMPLE_W-1:0] beep_out,
    output logic                       beep_active,
    output logic signed [SAMPLE_W-1:0] mix_out
);
    beep_state_t state;
    logic        phase_neg;

    beep_fsm #(
        .ONCODE_W (ONCODE_W),
        .OFFCODE_W(OFFCODE_W),
        .ON_UNIT  (ON_UNIT),
        .OFF_MIN  (OFF_MIN),
        .OFF_STEP (OFF_STEP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_en),
        .mode     (mode),
        .repeat_en(repeat_en),
        .on_code  (on_code),
        .off_code (off_code),
        .state    (state)
    );

    assign beep_active = (state == ST_TONE);

    beep_tone #(
        .FCODE_W (FCODE_W),
        .HALF_MAX(HALF_MAX),
        .HALF_MIN(HALF_MIN)
    ) u_tone (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_en),
        .run      (beep_active),
        .freq_code(freq_code),
        .phase_neg(phase_neg)
    );

    beep_mix #(
        .SAMPLE_W(SAMPLE_W),
        .AMP_W   (AMP_W)
    ) u_mix (
        .active   (beep_active),
        .phase_neg(phase_neg),
        .amp      (amp),
        .audio_in (audio_in),
        .beep_out (beep_out),
        .mix_out  (mix_out)
    );

endmodule

// File: rtl/beep_gen_chk.sv
module beep_gen_chk #(
    parameter int SAMPLE_W = 24,
    parameter int AMP_W    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sample_en,
    input logic [1:0]                 mode,
    input logic [AMP_W-1:0]           amp,
    input logic signed [SAMPLE_W-1:0] audio_in,
    input logic signed [SAMPLE_W-1:0] beep_out,
    input logic                       beep_active,
    input logic signed [SAMPLE_W-1:0] mix_out
);
    // R10
    silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beep_active |-> beep_out == '0);

    // R4
    tone_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beep_active && amp != '0) |-> beep_out != '0);

    // R9
    stop_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && mode == 2'b00) |=> !beep_active);

    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(beep_active));

    // R11
    mix_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beep_out == '0 |-> mix_out == audio_in);
endmodule

bind beep_gen beep_gen_chk #(.SAMPLE_W(SAMPLE_W), .AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .mode       (mode),
    .amp        (amp),
    .audio_in   (audio_in),
    .beep_out   (beep_out),
    .beep_active(beep_active),
    .mix_out    (mix_out)
);

// File: tb/tb_beep_gen.sv
module tb_beep_gen;
    localparam int PERIOD   = 10;
    localparam int ON_UNIT  = 8;
    localparam int OFF_MIN  = 20;
    localparam int OFF_STEP = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_en = 1'b0;
    logic [1:0]         mode = 2'b00;
    logic               repeat_en = 1'b0;
    logic [3:0]         freq_code = 4'd15;
    logic [3:0]         on_code = 4'd0;
    logic [2:0]         off_code = 3'd0;
    logic [7:0]         amp = 8'h40;
    logic signed [23:0] audio_in = 24'sd1000;
    logic signed [23:0] beep_out;
    logic               beep_active;
    logic signed [23:0] mix_out;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    beep_gen #(.ON_UNIT(ON_UNIT), .OFF_MIN(OFF_MIN), .OFF_STEP(OFF_STEP)) dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mode(mode),
        .repeat_en(repeat_en), .freq_code(freq_code), .on_code(on_code),
        .off_code(off_code), .amp(amp), .audio_in(audio_in),
        .beep_out(beep_out), .beep_active(beep_active), .mix_out(mix_out)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 idle, 1 tone, 2 gap, 3 done
    int m_st = 0, m_cnt = 0, m_tcnt = 0, m_neg = 0, m_enq = 0;

    function automatic int half_of(input int c);
        return 92 - (81 * c) / 15;
    endfunction

    task automatic model_step();
        int en, burst_len, gap_len;
        en = (mode != 2'b00);
        burst_len = ON_UNIT * (int'(on_code) + 1);
        gap_len = OFF_MIN + OFF_STEP * int'(off_code);
        if (m_st == 1) begin
            m_tcnt++;
            if (m_tcnt >= half_of(int'(freq_code))) begin
                m_tcnt = 0;
                m_neg = 1 - m_neg;
            end
        end else begin
            m_tcnt = 0;
            m_neg = 0;
        end
        if (!en) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            if (!m_enq) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
            if (mode[1] && !repeat_en) m_cnt = 0;
            else begin
                m_cnt++;
                if (m_cnt >= burst_len) begin
                    m_cnt = 0;
                    m_st = (mode == 2'b01) ? 3 : 2;
                end
            end
        end else if (m_st == 2) begin
            m_cnt++;
            if (m_cnt >= gap_len) begin m_cnt = 0; m_st = 1; end
        end
        m_enq = en;
    endtask

    task automatic compare();
        longint a, eb, em;
        int eact;
        eact = (m_st == 1);
        a = longint'(amp) * 32768;
        eb = eact ? (m_neg ? -a : a) : 0;
        em = longint'(audio_in) + eb;
        if (em > 8388607) em = 8388607;
        if (em < -8388608) em = -8388608;
        checks += 3;
        if (int'(beep_active) != eact) begin
            fails++;
            $display("FAIL %s/R10 beep_active actual %0d expected %0d at %0t", cur_req, beep_active, eact, $time);
        end
        if (longint'(beep_out) != eb) begin
            fails++;
            $display("FAIL %s/R3 beep_out actual %0d expected %0d at %0t", cur_req, beep_out, eb, $time);
        end
        if (longint'(mix_out) != em) begin
            fails++;
            $display("FAIL %s/R11 mix_out actual %0d expected %0d at %0t", cur_req, mix_out, em, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tcnt = 0; m_neg = 0; m_enq = 0;
        end else begin
            if (sample_en) model_step();
            #2;
            compare();
        end
    end

    task automatic run(input int n, input int stride);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_en = ((i % stride) == 0);
        end
    endtask

    task automatic set_cfg(input logic [1:0] md, input logic rp, input logic [3:0] fc,
                           input logic [3:0] oc, input logic [2:0] gc, input logic [7:0] am);
        @(negedge clk);
        mode = md; repeat_en = rp; freq_code = fc; on_code = oc; off_code = gc; amp = am;
        sample_en = 1'b1;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks += 3;
        if (beep_active !== 1'b0) begin fails++; $display("FAIL R1 beep_active actual %0d expected 0", beep_active); end
        if (beep_out !== 24'sd0) begin fails++; $display("FAIL R1 beep_out actual %0d expected 0", beep_out); end
        if (mix_out !== audio_in) begin fails++; $display("FAIL R1 mix_out actual %0d expected %0d", mix_out, audio_in); end
        rst_n = 1'b1;
        run(4, 1);

        cur_req = "R6";  set_cfg(2'b01, 1'b1, 4'd15, 4'd2, 3'd0, 8'h40); run(80, 1);
        cur_req = "R9";  set_cfg(2'b00, 1'b0, 4'd15, 4'd2, 3'd0, 8'h40); run(4, 1);
        cur_req = "R5";  set_cfg(2'b01, 1'b0, 4'd12, 4'd15, 3'd0, 8'h7F); run(160, 1);
        cur_req = "R9";  set_cfg(2'b00, 1'b0, 4'd12, 4'd15, 3'd0, 8'h7F); run(3, 1);
        cur_req = "R8";  set_cfg(2'b10, 1'b0, 4'd0, 4'd0, 3'd0, 8'h20); run(420, 1);
        cur_req = "R9";  set_cfg(2'b00, 1'b0, 4'd0, 4'd0, 3'd0, 8'h20); run(2, 1);
        cur_req = "R3";  set_cfg(2'b10, 1'b0, 4'd7, 4'd0, 3'd0, 8'h55); run(240, 1);
        cur_req = "R9";  set_cfg(2'b00, 1'b0, 4'd7, 4'd0, 3'd0, 8'h55); run(2, 1);
        cur_req = "R7";  set_cfg(2'b10, 1'b1, 4'd15, 4'd0, 3'd3, 8'h40); run(300, 1);
        cur_req = "R9";  set_cfg(2'b00, 1'b1, 4'd15, 4'd0, 3'd3, 8'h40); run(2, 1);
        cur_req = "R9";  set_cfg(2'b10, 1'b1, 4'd15, 4'd1, 3'd0, 8'h40); run(9, 1);
        set_cfg(2'b00, 1'b1, 4'd15, 4'd1, 3'd0, 8'h40); run(2, 1);
        set_cfg(2'b10, 1'b1, 4'd15, 4'd1, 3'd0, 8'h40); run(60, 1);
        set_cfg(2'b00, 1'b0, 4'd15, 4'd1, 3'd0, 8'h40); run(2, 1);
        cur_req = "R2";  set_cfg(2'b11, 1'b1, 4'd14, 4'd1, 3'd1, 8'h33); run(200, 1);
        set_cfg(2'b00, 1'b0, 4'd14, 4'd1, 3'd1, 8'h33); run(2, 1);
        cur_req = "R12"; set_cfg(2'b10, 1'b1, 4'd15, 4'd0, 3'd0, 8'h40); run(300, 3);
        set_cfg(2'b00, 1'b0, 4'd15, 4'd0, 3'd0, 8'h40); run(2, 1);
        cur_req = "R4";  set_cfg(2'b10, 1'b0, 4'd15, 4'd0, 3'd0, 8'hFF); run(40, 1);
        amp = 8'h01; run(40, 1);
        amp = 8'h00; run(30, 1);
        set_cfg(2'b00, 1'b0, 4'd15, 4'd0, 3'd0, 8'h00); run(2, 1);
        cur_req = "R11"; audio_in = 24'sh7FF000;
        set_cfg(2'b10, 1'b0, 4'd15, 4'd0, 3'd0, 8'hFF); run(50, 1);
        audio_in = -24'sh7FF000; run(50, 1);
        audio_in = 24'sd12345; run(30, 1);
        cur_req = "R10"; set_cfg(2'b00, 1'b0, 4'd15, 4'd0, 3'd0, 8'hFF); run(10, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule